// File: doc/BRIEF.md
# Serial port interrupt enable and cause identification

This block is the interrupt front end of a PC-compatible serial port register file. It stores which interrupt causes software has armed. It keeps a sticky pending flag for each of four causes: a receive error, receive data ready, transmit holding register empty, and a modem control line change. From the armed pending causes it drives one interrupt request line. It also forms an identification byte that names the most urgent armed cause.

Software reaches the block through a 3-bit register offset with read and write strobes. A separate input carries the divisor-latch select bit of the line control register. The datapath outside this block (shifters, baud timing, FIFOs, line status logic) is seen here only as single-cycle event pulses. It also supplies a level that says the transmit holding register is empty. Reads of the neighbouring status and data registers reach the block through the shared strobes, and those reads acknowledge their causes.

Top module: `uart_irq_front`

## Requirements
- R1: A synchronous active-high reset clears the enable register and all pending flags. Afterwards the enable register reads 0x00, the identification byte reads 0x01 and `irq` is low.
- R2: The enable register is written and read at offset 1 only while `dlab` is 0. Bits 3:0 store the write data and bits 7:4 always read 0. A write at offset 1 while `dlab` is 1 leaves the stored value unchanged. A read at offset 1 while `dlab` is 1 returns 0x00.
- R3: A read at offset 2 returns the identification byte. Bit 0 is 0 when any armed cause is pending and 1 otherwise, and bits 7:3 are always 0. With nothing armed and pending, the byte is 0x01.
- R4: Enable bit 2 arms receive error, bit 0 arms receive data, bit 1 arms transmit empty and bit 3 arms modem change. Identification bits 2:1 name the most urgent armed pending cause, in this order of urgency: receive error 11 (byte 0x06), receive data 10 (0x04), transmit empty 01 (0x02), modem change 00 (0x00).
- R5: `irq` is high exactly when at least one pending cause is armed. Clearing an enable bit hides its cause at once. The cause stays pending and appears again when the bit is set again.
- R6: A read of offset 2 that reports transmit empty as the most urgent cause clears that flag. An offset-2 read that reports a different cause leaves the transmit-empty flag set.
- R7: A write at offset 0 with `dlab` at 0 clears transmit empty. An `ev_tx_empty` pulse sets it. A write of enable bit 1 that changes it from 0 to 1 sets it when `tx_hold_empty` is high, and does not set it when `tx_hold_empty` is low.
- R8: A read at offset 5 clears receive error. A read at offset 0 with `dlab` at 0 clears receive data, and the same read with `dlab` at 1 does not. A read at offset 6 clears modem change.
- R9: When a set event and a clearing access for the same cause fall in the same cycle, the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| dlab | input | 1 | Divisor-latch select bit from the line control register |
| ev_line_err | input | 1 | Pulse: receive error (overrun, parity, framing, break) |
| ev_rx_ready | input | 1 | Pulse: received character available |
| ev_tx_empty | input | 1 | Pulse: transmit holding register became empty |
| ev_modem_chg | input | 1 | Pulse: modem control input changed |
| tx_hold_empty | input | 1 | Level: transmit holding register is empty now |
| rdata | output | 8 | Read data for offsets 1 and 2, zero elsewhere |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an identification read that must leave transmit empty pending because a more urgent cause hides it. Other edge cases are a set event that arrives in the same cycle as its own acknowledge, and an enable bit 1 that turns on while the holding register is already empty. Directed sequences build each of these states on purpose. A long run with a fixed seed then mixes sparse event pulses with random accesses at every offset and both `dlab` values. Every read and every `irq` sample is compared with a bench model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int IER_W  = 4;
  localparam int NCAUSE = 4;

  // Cause index equals its identification code; a higher index means more urgent.
  typedef enum logic [1:0] {
    CODE_MODEM = 2'b00,
    CODE_TXE   = 2'b01,
    CODE_RXD   = 2'b10,
    CODE_LINE  = 2'b11
  } cause_code_e;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IDR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LST  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MST  = 3'd6;

  // Reorder the enable bits into cause-index order.
  function automatic logic [NCAUSE-1:0] arm_mask(input logic [IER_W-1:0] en);
    logic [NCAUSE-1:0] m;
    m[CODE_LINE]  = en[2];
    m[CODE_RXD]   = en[0];
    m[CODE_TXE]   = en[1];
    m[CODE_MODEM] = en[3];
    return m;
  endfunction

  // Index of the highest set bit; 0 when the vector is empty.
  function automatic logic [1:0] top_cause(input logic [NCAUSE-1:0] v);
    logic [1:0] c;
    c = 2'd0;
    for (int i = 0; i < NCAUSE; i++)
      if (v[i]) c = 2'(i);
    return c;
  endfunction

  function automatic logic [7:0] id_byte(input logic any, input logic [1:0] code);
    return {5'b0, any ? code : 2'b00, ~any};
  endfunction
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IER_W-1:0] wdata,
  output logic [IER_W-1:0] en_q,
  output logic             txe_arm_rise
);
  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wdata;
  end

  assign txe_arm_rise = wr_en & wdata[1] & ~en_q[1];
endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCAUSE-1:0] set_i,
  input  logic [NCAUSE-1:0] clr_i,
  output logic [NCAUSE-1:0] pend_q
);
  for (genvar g = 0; g < NCAUSE; g++) begin : g_cause
    always_ff @(posedge clk) begin
      if (rst)           pend_q[g] <= 1'b0;
      else if (set_i[g]) pend_q[g] <= 1'b1;  // set wins over an acknowledge
      else if (clr_i[g]) pend_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NCAUSE-1:0] pend,
  input  logic [NCAUSE-1:0] mask,
  output logic              any,
  output logic [1:0]        code,
  output logic [7:0]        idr
);
  logic [NCAUSE-1:0] vis;
  assign vis  = pend & mask;
  assign any  = |vis;
  assign code = top_cause(vis);
  assign idr  = id_byte(any, code);
endmodule

// File: rtl/uart_irq_front.sv
module uart_irq_front
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dlab,
  input  logic              ev_line_err,
  input  logic              ev_rx_ready,
  input  logic              ev_tx_empty,
  input  logic              ev_modem_chg,
  input  logic              tx_hold_empty,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PAD_W = DATA_W - IER_W;

  logic              ien_wr, idr_rd, thr_wr;
  logic [IER_W-1:0]  en_q;
  logic              txe_arm_rise;
  logic [NCAUSE-1:0] set_v, clr_v, pend_q, mask_v;
  logic              any_pend;
  logic [1:0]        top_code;
  logic [7:0]        idr_v;
  logic              idr_pend_n;

  assign ien_wr = reg_wr & (reg_addr == OFS_IEN) & ~dlab;
  assign idr_rd = reg_rd & (reg_addr == OFS_IDR);
  assign thr_wr = reg_wr & (reg_addr == OFS_DATA) & ~dlab;

  uart_irq_enable u_en (
    .clk(clk), .rst(rst), .wr_en(ien_wr), .wdata(wdata[IER_W-1:0]),
    .en_q(en_q), .txe_arm_rise(txe_arm_rise)
  );

  always_comb begin
    set_v = '0;
    set_v[CODE_LINE]  = ev_line_err;
    set_v[CODE_RXD]   = ev_rx_ready;
    set_v[CODE_TXE]   = ev_tx_empty | (txe_arm_rise & tx_hold_empty);
    set_v[CODE_MODEM] = ev_modem_chg;
    clr_v = '0;
    clr_v[CODE_LINE]  = reg_rd & (reg_addr == OFS_LST);
    clr_v[CODE_RXD]   = reg_rd & (reg_addr == OFS_DATA) & ~dlab;
    clr_v[CODE_TXE]   = (idr_rd & any_pend & (top_code == CODE_TXE)) | thr_wr;
    clr_v[CODE_MODEM] = reg_rd & (reg_addr == OFS_MST);
  end

  uart_irq_latch u_latch (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .pend_q(pend_q)
  );

  assign mask_v = arm_mask(en_q);

  uart_irq_prio u_prio (
    .pend(pend_q), .mask(mask_v), .any(any_pend), .code(top_code), .idr(idr_v)
  );

  assign idr_pend_n = idr_v[0];
  assign irq        = any_pend;

  always_comb begin
    rdata = '0;
    if (reg_addr == OFS_IEN && !dlab) rdata = {{PAD_W{1'b0}}, en_q};
    else if (reg_addr == OFS_IDR)     rdata = {{(DATA_W-8){1'b0}}, idr_v};
  end
endmodule

// File: rtl/uart_irq_front_chk.sv
module uart_irq_front_chk
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              dlab,
  input logic              ev_line_err,
  input logic              ev_rx_ready,
  input logic              ev_tx_empty,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [NCAUSE-1:0] pend_q,
  input logic              idr_pend_n
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq && pend_q == '0);

  a_r2_ien_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFS_IEN && !dlab) |-> rdata[DATA_W-1:IER_W] == '0);

  a_r3_irq_vs_id: assert property (@(posedge clk) disable iff (rst)
    irq != idr_pend_n);

  a_r3_id_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFS_IDR) |-> rdata[DATA_W-1:3] == '0);

  a_r6_txe_ack: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_IDR && rdata[2:0] == 3'b010 && !ev_tx_empty)
      |=> !pend_q[CODE_TXE]);

  a_r8_line_ack: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_LST && !ev_line_err) |=> !pend_q[CODE_LINE]);

  a_r9_rx_set_wins: assert property (@(posedge clk) disable iff (rst)
    ev_rx_ready |=> pend_q[CODE_RXD]);
endmodule

bind uart_irq_front uart_irq_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .dlab(dlab),
  .ev_line_err(ev_line_err), .ev_rx_ready(ev_rx_ready), .ev_tx_empty(ev_tx_empty),
  .rdata(rdata), .irq(irq), .pend_q(pend_q), .idr_pend_n(idr_pend_n)
);

// File: tb/uart_irq_front_tb.sv
`timescale 1ns/1ps
module uart_irq_front_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0, dlab = 1'b0;
  logic [7:0] wdata = '0;
  logic       ev_line_err = 0, ev_rx_ready = 0, ev_tx_empty = 0, ev_modem_chg = 0;
  logic       tx_hold_empty = 0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0;

  // bench model
  logic m_line = 0, m_rx = 0, m_tx = 0, m_ms = 0;
  logic [3:0] m_en = '0;

  always #2 clk = ~clk;

  uart_irq_front u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .wdata(wdata), .dlab(dlab), .ev_line_err(ev_line_err), .ev_rx_ready(ev_rx_ready),
    .ev_tx_empty(ev_tx_empty), .ev_modem_chg(ev_modem_chg),
    .tx_hold_empty(tx_hold_empty), .rdata(rdata), .irq(irq)
  );

  function automatic logic [7:0] exp_id();
    if (m_line && m_en[2]) return 8'h06;
    if (m_rx   && m_en[0]) return 8'h04;
    if (m_tx   && m_en[1]) return 8'h02;
    if (m_ms   && m_en[3]) return 8'h00;
    return 8'h01;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a, input logic dl);
    if (a == 3'd1 && !dl) return {4'h0, m_en};
    if (a == 3'd2) return exp_id();
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One bus cycle; ev = {line, rx, tx, modem}
  task automatic step(input string tag, input logic [2:0] a, input logic rd,
                      input logic wr, input logic [7:0] wd, input logic dl,
                      input logic [3:0] ev, input logic txl);
    logic [7:0] id_pre;
    logic cl_line, cl_rx, cl_tx, cl_ms, st_tx;
    @(negedge clk);
    reg_addr = a; reg_rd = rd; reg_wr = wr; wdata = wd; dlab = dl;
    {ev_line_err, ev_rx_ready, ev_tx_empty, ev_modem_chg} = ev;
    tx_hold_empty = txl;
    #1;
    id_pre = exp_id();
    if (rd) chk({tag, " read"}, rdata, exp_read(a, dl));
    chk({tag, " irq (R5)"}, {7'b0, irq}, {7'b0, id_pre[0] == 1'b0});
    cl_line = rd && a == 3'd5;
    cl_rx   = rd && a == 3'd0 && !dl;
    cl_ms   = rd && a == 3'd6;
    cl_tx   = (rd && a == 3'd2 && id_pre == 8'h02) || (wr && a == 3'd0 && !dl);
    st_tx   = ev[1] || (wr && a == 3'd1 && !dl && wd[1] && !m_en[1] && txl);
    @(posedge clk);
    m_line = ev[3] | (m_line & ~cl_line);
    m_rx   = ev[2] | (m_rx & ~cl_rx);
    m_tx   = st_tx | (m_tx & ~cl_tx);
    m_ms   = ev[0] | (m_ms & ~cl_ms);
    if (wr && a == 3'd1 && !dl) m_en = wd[3:0];
  endtask

  task automatic rd_id(input string tag);
    step(tag, 3'd2, 1, 0, 8'h00, 0, 4'b0000, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: state after reset
    rd_id("R1 id after reset");
    step("R1 ien after reset", 3'd1, 1, 0, 0, 0, 4'b0000, 0);
    // R2: upper bits, dlab gating
    step("R2 write", 3'd1, 0, 1, 8'hF0, 0, 4'b0000, 0);
    step("R2 upper zero", 3'd1, 1, 0, 0, 0, 4'b0000, 0);
    step("R2 write", 3'd1, 0, 1, 8'hFF, 0, 4'b0000, 0);
    step("R2 dlab write ignored", 3'd1, 0, 1, 8'h00, 1, 4'b0000, 0);
    step("R2 dlab read", 3'd1, 1, 0, 0, 1, 4'b0000, 0);
    step("R2 readback", 3'd1, 1, 0, 0, 0, 4'b0000, 0);
    // R4 priority ladder, R8 / R6 acknowledges
    step("R4 modem", 3'd7, 0, 0, 0, 0, 4'b0001, 1); rd_id("R4 modem code");
    step("R4 tx", 3'd7, 0, 0, 0, 0, 4'b0010, 1);    rd_id("R4 tx code, R6 clears");
    step("R4 tx", 3'd7, 0, 0, 0, 0, 4'b0010, 1);
    step("R4 rx", 3'd7, 0, 0, 0, 0, 4'b0100, 1);    rd_id("R4 rx code, R6 keeps tx");
    step("R4 line", 3'd7, 0, 0, 0, 0, 4'b1000, 1);  rd_id("R4 line code");
    step("R8 lsr read", 3'd5, 1, 0, 0, 0, 4'b0000, 1); rd_id("R8 line cleared");
    step("R8 rbr dlab1", 3'd0, 1, 0, 0, 1, 4'b0000, 1); rd_id("R8 rx kept");
    step("R8 rbr read", 3'd0, 1, 0, 0, 0, 4'b0000, 1); rd_id("R6 tx reported");
    rd_id("R6 tx cleared");
    step("R8 msr read", 3'd6, 1, 0, 0, 0, 4'b0000, 1); rd_id("R3 idle 0x01");
    // R5 masking
    step("R5 rx", 3'd7, 0, 0, 0, 0, 4'b0100, 0);
    step("R5 mask", 3'd1, 0, 1, 8'h00, 0, 4'b0000, 0); rd_id("R5 hidden");
    step("R5 unmask", 3'd1, 0, 1, 8'h01, 0, 4'b0000, 0); rd_id("R5 reappears");
    step("R8 rbr read", 3'd0, 1, 0, 0, 0, 4'b0000, 0);
    // R7 arm rise / thr write
    step("R7 arm, not empty", 3'd1, 0, 1, 8'h02, 0, 4'b0000, 0); rd_id("R7 no set");
    step("R7 disarm", 3'd1, 0, 1, 8'h00, 0, 4'b0000, 1);
    step("R7 arm, empty", 3'd1, 0, 1, 8'h02, 0, 4'b0000, 1); rd_id("R7 armed set/R6 clear");
    step("R7 tx ev", 3'd7, 0, 0, 0, 0, 4'b0010, 1);
    step("R7 thr write", 3'd0, 0, 1, 8'h55, 0, 4'b0000, 0); rd_id("R7 thr cleared");
    // R9 set wins
    step("R9 en all", 3'd1, 0, 1, 8'h0F, 0, 4'b0000, 0);
    step("R9 lsr+ev", 3'd5, 1, 0, 0, 0, 4'b1000, 0); rd_id("R9 line kept");
    step("R9 rbr+ev", 3'd0, 1, 0, 0, 0, 4'b0100, 0);
    step("R8 lsr read", 3'd5, 1, 0, 0, 0, 4'b0000, 0); rd_id("R9 rx kept");
    // random mix, fixed seed
    void'($urandom(32'h1ACE));
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a; logic op; logic [3:0] ev; logic dl;
      a  = 3'($urandom_range(0, 7));
      op = 1'($urandom_range(0, 1));
      dl = ($urandom_range(0, 5) == 0);
      ev = '0;
      for (int k = 0; k < 4; k++) ev[k] = ($urandom_range(0, 9) == 0);
      step("R4 random", a, op, ~op, 8'($urandom), dl, ev, 1'($urandom_range(0, 1)));
    end
    // R1 again after reset
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    m_line = 0; m_rx = 0; m_tx = 0; m_ms = 0; m_en = '0;
    @(negedge clk); rst = 1'b0;
    rd_id("R1 id after second reset");
    step("R1 ien after second reset", 3'd1, 1, 0, 0, 0, 4'b0000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule